// File: doc/BRIEF.md
# Escape Sequence Guard-Time Detector

This block watches the byte stream coming out of a serial receiver and recognises a modem-style escape request: a quiet stretch on the line, a short burst of one particular character repeated a set number of times, and then another quiet stretch. Both content and timing matter. The characters must be identical and must match a configured value, they must follow each other closely, and the line must stay silent both before and after the burst. When the whole pattern has been seen, the block raises a single-cycle detection pulse that the surrounding logic can use to switch a link from data mode to command mode.

Time is measured in bit ticks, a strobe that the receiver's baud generator supplies once per bit period. One shared quiet timer counts ticks while the line is idle and no byte arrives. Any received byte or any activity on the line clears it. The five settings (escape character, run length, leading guard, trailing guard and maximum gap between characters) sit in a small register set. One write strobe loads all five at once, and reset returns them to defaults that suit a conventional escape sequence.

Top module: `esc_seq_detect`

## Requirements
- R1: After reset `detect` is low and the settings are: escape character 0x2B, run length 3, leading guard 2305 ticks, trailing guard 2305 ticks, maximum gap 11 ticks.
- R2: A cycle with `cfg_wr` high loads all five settings from the `cfg_*` inputs. The new values apply from the next cycle.
- R3: The quiet timer counts one per `bit_tick` while `line_idle` is high and no byte is valid, and saturates at its maximum. It returns to zero in the cycle after a valid byte, or after a cycle with `line_idle` low.
- R4: While the detector waits, an escape byte starts a run only when the quiet timer is at least the leading guard as the byte arrives. An equal value is accepted, and one tick short is rejected.
- R5: Within a run, each further escape byte must arrive with the quiet timer at or below the maximum gap. If the timer exceeds the gap, the run is abandoned at once and the detector returns to waiting.
- R6: A byte that is not the escape character, received during a run, abandons the run.
- R7: After the final escape byte, detection happens in the cycle in which the quiet timer reaches the trailing guard, even if a byte arrives in that same cycle. Any byte that arrives earlier abandons the sequence.
- R8: An escape byte beyond the configured run length, arriving inside the trailing guard, abandons the sequence without detection.
- R9: `detect` is high for exactly one clock cycle for each recognised sequence. With the registered output it rises one cycle after the cycle in which the trailing guard is met.
- R10: A run length of 1 makes a single guarded escape byte a complete sequence. A run length of 0 never produces a detection.
- R11: After a detection or an abandoned attempt, the detector returns to waiting, and a later valid sequence is recognised normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| line_idle | input | 1 | High while the receive line is idle |
| rx_vld | input | 1 | Received byte valid strobe |
| rx_data | input | CHAR_W | Received byte |
| cfg_wr | input | 1 | Load strobe for all settings |
| cfg_esc | input | CHAR_W | Escape character to load |
| cfg_cnt | input | CNT_W | Run length to load |
| cfg_pre | input | TIME_W | Leading guard in ticks to load |
| cfg_post | input | TIME_W | Trailing guard in ticks to load |
| cfg_gap | input | TIME_W | Maximum inter-character gap in ticks to load |
| detect | output | 1 | One-cycle pulse on a recognised sequence |

## Verification
The bench drives the guard and gap limits on both sides of each comparison. A leading guard one tick short must be rejected and an exact one accepted. A gap one tick too long must abort, and the tests catch a design that uses the wrong inequality because it would detect or miss by a single tick. A byte just inside the trailing guard must kill the sequence, while a byte landing exactly as the guard completes must not. A fourth escape character, a foreign character in the middle of a run, a busy line that should hold the timer at zero, run lengths of 0 and 1, and a changed escape character are each run. A design that counted through these cases, ignored `line_idle`, or kept stale settings would produce a detection count different from the expected one. The defaults are checked by a full-length sequence sent straight after reset.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;

   typedef enum logic [1:0] {
      ST_WAIT = 2'd0,
      ST_RUN  = 2'd1,
      ST_POST = 2'd2
   } esc_state_e;

   localparam int unsigned DEF_ESC_CHAR  = 32'h2B;
   localparam int unsigned DEF_RUN_LEN   = 3;
   localparam int unsigned DEF_LEAD_TKS  = 2305;
   localparam int unsigned DEF_TRAIL_TKS = 2305;
   localparam int unsigned DEF_GAP_TKS   = 11;

endpackage

// File: rtl/esc_idle_timer.sv
module esc_idle_timer #(
   parameter int unsigned TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              line_idle,
   input  logic              byte_vld,
   output logic [TIME_W-1:0] quiet
);

   localparam logic [TIME_W-1:0] SAT = {TIME_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quiet <= '0;
      end else if (byte_vld || !line_idle) begin
         quiet <= '0;
      end else if (bit_tick && (quiet != SAT)) begin
         quiet <= quiet + 1'b1;
      end
   end

endmodule

// File: rtl/esc_cfg_regs.sv
module esc_cfg_regs #(
   parameter int unsigned            CHAR_W    = 8,
   parameter int unsigned            CNT_W     = 8,
   parameter int unsigned            TIME_W    = 16,
   parameter logic [CHAR_W-1:0]      DEF_ESC   = 8'h2B,
   parameter logic [CNT_W-1:0]       DEF_CNT   = 3,
   parameter logic [TIME_W-1:0]      DEF_PRE   = 2305,
   parameter logic [TIME_W-1:0]      DEF_POST  = 2305,
   parameter logic [TIME_W-1:0]      DEF_GAP   = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [CHAR_W-1:0] cfg_esc,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic [TIME_W-1:0] cfg_pre,
   input  logic [TIME_W-1:0] cfg_post,
   input  logic [TIME_W-1:0] cfg_gap,
   output logic [CHAR_W-1:0] esc_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [TIME_W-1:0] pre_q,
   output logic [TIME_W-1:0] post_q,
   output logic [TIME_W-1:0] gap_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         esc_q  <= DEF_ESC;
         cnt_q  <= DEF_CNT;
         pre_q  <= DEF_PRE;
         post_q <= DEF_POST;
         gap_q  <= DEF_GAP;
      end else if (cfg_wr) begin
         esc_q  <= cfg_esc;
         cnt_q  <= cfg_cnt;
         pre_q  <= cfg_pre;
         post_q <= cfg_post;
         gap_q  <= cfg_gap;
      end
   end

endmodule

// File: rtl/esc_seq_fsm.sv
module esc_seq_fsm
   import esc_seq_pkg::*;
#(
   parameter int unsigned CHAR_W = 8,
   parameter int unsigned CNT_W  = 8,
   parameter int unsigned TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_vld,
   input  logic [CHAR_W-1:0] byte_data,
   input  logic [TIME_W-1:0] quiet,
   input  logic [CHAR_W-1:0] esc_q,
   input  logic [CNT_W-1:0]  cnt_q,
   input  logic [TIME_W-1:0] pre_q,
   input  logic [TIME_W-1:0] post_q,
   input  logic [TIME_W-1:0] gap_q,
   output esc_state_e        st,
   output logic              fire
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   esc_state_e       st_n;
   logic [CNT_W-1:0] hits, hits_n, hits_inc;
   logic             is_esc;

   assign is_esc   = (byte_data == esc_q);
   assign hits_inc = hits + ONE;
   assign fire     = (st == ST_POST) && (quiet >= post_q);

   always_comb begin
      st_n   = st;
      hits_n = hits;
      unique case (st)
         ST_WAIT: begin
            if (byte_vld && is_esc && (quiet >= pre_q) && (cnt_q != '0)) begin
               hits_n = ONE;
               st_n   = (cnt_q == ONE) ? ST_POST : ST_RUN;
            end
         end
         ST_RUN: begin
            if (byte_vld) begin
               if (is_esc && (quiet <= gap_q)) begin
                  hits_n = hits_inc;
                  if (hits_inc == cnt_q) st_n = ST_POST;
               end else begin
                  st_n = ST_WAIT;
               end
            end else if (quiet > gap_q) begin
               st_n = ST_WAIT;
            end
         end
         ST_POST: begin
            if (fire || byte_vld) st_n = ST_WAIT;
         end
         default: st_n = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_WAIT;
         hits <= '0;
      end else begin
         st   <= st_n;
         hits <= hits_n;
      end
   end

endmodule

// File: rtl/esc_seq_detect.sv
module esc_seq_detect
   import esc_seq_pkg::*;
#(
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned TIME_W  = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              line_idle,
   input  logic              rx_vld,
   input  logic [CHAR_W-1:0] rx_data,
   input  logic              cfg_wr,
   input  logic [CHAR_W-1:0] cfg_esc,
   input  logic [CNT_W-1:0]  cfg_cnt,
   input  logic [TIME_W-1:0] cfg_pre,
   input  logic [TIME_W-1:0] cfg_post,
   input  logic [TIME_W-1:0] cfg_gap,
   output logic              detect
);

   localparam logic [CHAR_W-1:0] RST_ESC  = CHAR_W'(DEF_ESC_CHAR);
   localparam logic [CNT_W-1:0]  RST_CNT  = CNT_W'(DEF_RUN_LEN);
   localparam logic [TIME_W-1:0] RST_PRE  = TIME_W'(DEF_LEAD_TKS);
   localparam logic [TIME_W-1:0] RST_POST = TIME_W'(DEF_TRAIL_TKS);
   localparam logic [TIME_W-1:0] RST_GAP  = TIME_W'(DEF_GAP_TKS);

   // elaboration-time parameter checks
   if (CHAR_W < 1 || CHAR_W > 32) begin : g_bad_char
      $error("esc_seq_detect: CHAR_W out of range");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("esc_seq_detect: CNT_W out of range");
   end
   if (TIME_W < 12 || TIME_W > 32) begin : g_bad_time
      $error("esc_seq_detect: TIME_W too small for default guard times");
   end

   logic [CHAR_W-1:0] esc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [TIME_W-1:0] pre_q, post_q, gap_q;
   logic [TIME_W-1:0] quiet;
   esc_state_e        st;
   logic              fire;

   esc_cfg_regs #(
      .CHAR_W(CHAR_W), .CNT_W(CNT_W), .TIME_W(TIME_W),
      .DEF_ESC(RST_ESC), .DEF_CNT(RST_CNT), .DEF_PRE(RST_PRE),
      .DEF_POST(RST_POST), .DEF_GAP(RST_GAP)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
      .cfg_esc(cfg_esc), .cfg_cnt(cfg_cnt), .cfg_pre(cfg_pre),
      .cfg_post(cfg_post), .cfg_gap(cfg_gap),
      .esc_q(esc_q), .cnt_q(cnt_q), .pre_q(pre_q),
      .post_q(post_q), .gap_q(gap_q)
   );

   esc_idle_timer #(.TIME_W(TIME_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
      .line_idle(line_idle), .byte_vld(rx_vld), .quiet(quiet)
   );

   esc_seq_fsm #(.CHAR_W(CHAR_W), .CNT_W(CNT_W), .TIME_W(TIME_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .byte_vld(rx_vld), .byte_data(rx_data),
      .quiet(quiet), .esc_q(esc_q), .cnt_q(cnt_q), .pre_q(pre_q),
      .post_q(post_q), .gap_q(gap_q), .st(st), .fire(fire)
   );

   if (OUT_REG) begin : g_out_reg
      logic detect_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) detect_q <= 1'b0;
         else        detect_q <= fire;
      end
      assign detect = detect_q;
   end else begin : g_out_comb
      assign detect = fire;
   end

endmodule

// File: rtl/esc_seq_detect_chk.sv
module esc_seq_detect_chk
   import esc_seq_pkg::*;
#(
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned TIME_W  = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_vld,
   input logic              line_idle,
   input logic              cfg_wr,
   input logic [CHAR_W-1:0] cfg_esc,
   input logic [CNT_W-1:0]  cfg_cnt,
   input logic [TIME_W-1:0] cfg_pre,
   input logic [TIME_W-1:0] cfg_post,
   input logic [TIME_W-1:0] cfg_gap,
   input logic [CHAR_W-1:0] esc_q,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [TIME_W-1:0] pre_q,
   input logic [TIME_W-1:0] post_q,
   input logic [TIME_W-1:0] gap_q,
   input logic [TIME_W-1:0] quiet,
   input esc_state_e        st,
   input logic              detect
);

   AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |=> (esc_q == $past(cfg_esc)) && (cnt_q == $past(cfg_cnt)) && (pre_q == $past(cfg_pre)) && (post_q == $past(cfg_post)) && (gap_q == $past(cfg_gap))); // R2

   AST_QUIET_BYTE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      rx_vld |=> (quiet == '0)); // R3

   AST_QUIET_BUSY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      !line_idle |=> (quiet == '0)); // R3

   AST_LEAD_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT && rx_vld && quiet < pre_q) |=> (st == ST_WAIT)); // R4

   AST_GAP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !rx_vld && quiet > gap_q) |=> (st == ST_WAIT)); // R5

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      detect |=> !detect); // R9

   if (OUT_REG) begin : g_reg_chk
      AST_PULSE_FROM_POST: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(detect) |-> ($past(st) == ST_POST)); // R9
   end

endmodule

bind esc_seq_detect esc_seq_detect_chk #(
   .CHAR_W(CHAR_W), .CNT_W(CNT_W), .TIME_W(TIME_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .line_idle(line_idle),
   .cfg_wr(cfg_wr), .cfg_esc(cfg_esc), .cfg_cnt(cfg_cnt), .cfg_pre(cfg_pre),
   .cfg_post(cfg_post), .cfg_gap(cfg_gap), .esc_q(esc_q), .cnt_q(cnt_q),
   .pre_q(pre_q), .post_q(post_q), .gap_q(gap_q), .quiet(quiet),
   .st(st), .detect(detect)
);

// File: tb/test_esc_seq_detect.sv
module test_esc_seq_detect;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_tick = 1'b0;
   logic        line_idle = 1'b1;
   logic        rx_vld = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_esc = 8'h00;
   logic [7:0]  cfg_cnt = 8'h00;
   logic [15:0] cfg_pre = 16'h0, cfg_post = 16'h0, cfg_gap = 16'h0;
   logic        detect;

   int checks = 0;
   int errors = 0;
   int seen   = 0;
   bit done   = 1'b0;
   logic [1:0] tick_ctr = 2'd0;

   typedef struct {
      string tag;
      int    exp;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   // exactly one tick in every four consecutive cycles
   always @(posedge clk) begin
      tick_ctr <= tick_ctr + 2'd1;
      bit_tick <= (tick_ctr == 2'd3);
   end

   esc_seq_detect i_esc_seq_detect (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .line_idle(line_idle),
      .rx_vld(rx_vld), .rx_data(rx_data), .cfg_wr(cfg_wr), .cfg_esc(cfg_esc),
      .cfg_cnt(cfg_cnt), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
      .cfg_gap(cfg_gap), .detect(detect)
   );

   // monitor: counts pulses and compares against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && detect) seen = seen + 1;
      if (exp_q.size() > 0) begin
         exp_t it;
         it = exp_q.pop_front();
         checks = checks + 1;
         if (seen != it.exp) begin
            errors = errors + 1;
            $display("FAIL %s: detections actual %0d expected %0d", it.tag, seen, it.exp);
         end
         seen = 0;
      end
   end

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic ticks(input int n);
      repeat (4 * n) cyc();
   endtask

   task automatic send(input logic [7:0] b);
      rx_vld  = 1'b1;
      rx_data = b;
      cyc();
      rx_vld  = 1'b0;
      rx_data = 8'h00;
   endtask

   task automatic load_cfg(input logic [7:0] e, input logic [7:0] n,
                           input logic [15:0] pr, input logic [15:0] po,
                           input logic [15:0] g);
      cfg_esc = e; cfg_cnt = n; cfg_pre = pr; cfg_post = po; cfg_gap = g;
      cfg_wr = 1'b1;
      cyc();
      cfg_wr = 1'b0;
   endtask

   task automatic expect_n(input string tag, input int n);
      repeat (3) cyc();
      exp_q.push_back('{tag, n});
      repeat (2) cyc();
   endtask

   // lead byte (non-escape), guard, run of n escapes with gap g, trailing wait
   task automatic esc_run(input string tag, input logic [7:0] ch, input int lead,
                          input int n, input int g, input int tail, input int exp);
      send(8'h5A);
      ticks(lead);
      for (int i = 0; i < n; i++) begin
         if (i > 0) ticks(g);
         send(ch);
      end
      ticks(tail);
      expect_n(tag, exp);
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      checks = checks + 1;
      if (detect !== 1'b0) begin
         errors = errors + 1;
         $display("FAIL R1: detect after reset actual %b expected 0", detect);
      end

      // R1 defaults: 0x2B, 3 chars, 2305 lead, 2305 trail, 11 gap
      esc_run("R1 defaults", 8'h2B, 2305, 3, 11, 2310, 1);

      load_cfg(8'h2B, 8'd3, 16'd20, 16'd20, 16'd5);
      esc_run("R4 R9 lead equal", 8'h2B, 20, 3, 3, 25, 1);
      esc_run("R4 lead short", 8'h2B, 19, 3, 3, 25, 0);
      esc_run("R5 gap equal", 8'h2B, 25, 3, 5, 25, 1);
      esc_run("R5 gap long", 8'h2B, 25, 3, 6, 25, 0);
      esc_run("R8 extra escape", 8'h2B, 25, 4, 3, 25, 0);

      // R6 foreign byte in the run
      send(8'h5A); ticks(25);
      send(8'h2B); ticks(3); send(8'h58); ticks(3);
      send(8'h2B); ticks(3); send(8'h2B); ticks(25);
      expect_n("R6 foreign byte", 0);

      // R7 byte one tick inside trailing guard
      send(8'h5A); ticks(25);
      send(8'h2B); ticks(3); send(8'h2B); ticks(3); send(8'h2B);
      ticks(19); send(8'h42); ticks(30);
      expect_n("R7 early byte", 0);

      // R7 byte exactly as the trailing guard completes
      send(8'h5A); ticks(25);
      send(8'h2B); ticks(3); send(8'h2B); ticks(3); send(8'h2B);
      ticks(20); send(8'h42); ticks(30);
      expect_n("R7 byte at guard", 1);

      // R3 busy line holds the timer at zero
      send(8'h5A);
      line_idle = 1'b0; ticks(30);
      line_idle = 1'b1; ticks(15);
      send(8'h2B); ticks(3); send(8'h2B); ticks(3); send(8'h2B); ticks(25);
      expect_n("R3 busy line", 0);

      // R2 R10 new escape char and run length 1
      load_cfg(8'h41, 8'd1, 16'd20, 16'd20, 16'd5);
      esc_run("R2 R10 single char", 8'h41, 25, 1, 3, 25, 1);
      esc_run("R2 old char ignored", 8'h2B, 25, 3, 3, 25, 0);

      load_cfg(8'h2B, 8'd0, 16'd20, 16'd20, 16'd5);
      esc_run("R10 zero length", 8'h2B, 25, 3, 3, 25, 0);

      load_cfg(8'h2B, 8'd3, 16'd20, 16'd20, 16'd5);
      esc_run("R11 recover", 8'h2B, 25, 3, 4, 25, 1);

      repeat (4) cyc();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule